// File: doc/BRIEF.md
# Slot Mailbox Register Interface

This block is the device end of a word-wide mailbox between a host and an embedded engine. It holds two circular buffers of 32-bit slots. The outbound buffer carries words from the host to the engine. The inbound buffer carries words from the engine to the host. The host reaches the block through a four-word register window. It pushes words through a write window, pops words through a read window, and reads two status words. The engine pushes and pops through simple one-cycle strobes and has its own status word, which it reads directly and updates through a control write.

Occupancy is not shown as full or empty flags. Each status word carries the free-running 8-bit write and read pointers of one buffer, together with the buffer depth in slots. Software finds the filled count as the 8-bit difference of the two pointers, and the free count as the depth minus that. The same status words carry interrupt enable, interrupt status, interrupt generate (a doorbell toward the other side), ready, reset and a sticky error flag. The reset and ready bits form a two-sided handshake: the host raises reset, the engine announces ready again, and the host then drops reset and declares itself ready.

Top module: `mbox_top`

## Requirements
- R1: After reset both status words read as the depth in bits 31:24 with every other bit 0, and neither interrupt output is asserted.
- R2: A host write at byte offset 0x00 appends one slot to the outbound buffer and advances the write pointer (host status bits 23:16). Each engine pop returns the oldest outbound word and advances the read pointer (host status bits 15:8), so words arrive in the order they were written.
- R3: An engine push appends one slot to the inbound buffer and advances the write pointer (engine status bits 23:16). Each host read at offset 0x08 returns the oldest inbound word and advances the read pointer (engine status bits 15:8).
- R4: Pointers are 8 bits wide and wrap freely modulo 256. The filled count (write pointer minus read pointer, as 8 bits) never exceeds the depth.
- R5: A host write to a full outbound buffer is dropped: the write pointer holds and the host error flag (status bit 5) is set. The flag stays set until the host writes 1 to bit 5 of the host status word at offset 0x04.
- R6: A host read at 0x08 with the inbound buffer empty returns 0, leaves both inbound pointers unchanged, and sets the host error flag.
- R7: On the engine side, a pop of an empty outbound buffer returns 0 and a push to a full inbound buffer is dropped. Both set the engine error flag (engine status bit 5), which the engine clears by writing 1 to bit 5 through its control write.
- R8: A host status write with bit 2 set gives a one-cycle engine doorbell pulse and sets engine interrupt status (bit 1). Bit 2 always reads 0. The engine interrupt is asserted while engine status bit 1 and enable bit 0 are both 1. The engine clears bit 1 by writing 1 to it.
- R9: An engine control write with bit 2 set gives a one-cycle host doorbell pulse and sets host interrupt status (bit 1). The host interrupt is asserted while host bits 1 and 0 are both 1. A host status write with bit 1 set clears the status.
- R10: A host status write with reset (bit 4) set empties both buffers (all four pointers read 0) and clears the host ready bit (bit 3) and the engine ready bit. While host reset stays 1, every push and pop from either side is ignored and no error is flagged.
- R11: Once the engine has set its ready bit again, a host status write with reset 0 and ready 1 makes the host status read ready 1 and reset 0, and traffic flows again.
- R12: Host writes at offsets 0x08 and 0x0C have no effect, and a host read at 0x00 returns 0.
- R13: Bits 31:24 of both status words always hold the depth parameter. Bits 7:6 read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| hostWrEn | input | 1 | Host write strobe for the window |
| hostRdEn | input | 1 | Host read strobe for the window |
| hostAddr | input | 2 | Word select, byte address bits 3:2 |
| hostWrData | input | 32 | Host write data |
| hostRdData | output | 32 | Host read data, valid in the same cycle as the strobe |
| engPush | input | 1 | Engine push into the inbound buffer |
| engPushData | input | 32 | Word pushed by the engine |
| engPop | input | 1 | Engine pop from the outbound buffer |
| engPopData | output | 32 | Oldest outbound word, 0 when empty |
| engCsrWr | input | 1 | Engine control write strobe |
| engCsrWrData | input | 6 | Engine control bits: 0 enable, 1 clear status, 2 doorbell, 3 ready, 4 reset, 5 clear error |
| engStatus | output | 32 | Engine status word |
| hostIrq | output | 1 | Host interrupt |
| engIrq | output | 1 | Engine interrupt |
| hostDoorbell | output | 1 | One-cycle pulse toward the host |
| engDoorbell | output | 1 | One-cycle pulse toward the engine |

## Verification
The bench drives traffic long enough to wrap the 8-bit pointers past 256. A design that compared pointers at full width or indexed storage wrongly would report a false full or return words out of order there. It fills each buffer to its exact depth and then pushes once more, and it also reads each buffer when empty. A design with an off-by-one full test, or one that let an empty read move a pointer, would show a wrong pointer or a corrupted word. It holds host reset while traffic is offered, to catch a design that still takes writes or flags errors during the flush, or that keeps a stale engine ready bit across it. Doorbell pulses are checked for exactly one cycle, and interrupt status is checked for write-one-to-clear, not plain overwrite.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

  localparam int PTR_W  = 8;
  localparam int WORD_W = 32;

  // control/status bit positions shared by both sides
  localparam int BIT_IE  = 0;
  localparam int BIT_IS  = 1;
  localparam int BIT_IG  = 2;
  localparam int BIT_RDY = 3;
  localparam int BIT_RST = 4;
  localparam int BIT_ERR = 5;
  localparam int RP_LSB  = 8;
  localparam int WP_LSB  = 16;
  localparam int DEP_LSB = 24;

  typedef enum logic [1:0] {
    SEL_TXWIN = 2'd0,
    SEL_HOSTREG = 2'd1,
    SEL_RXWIN = 2'd2,
    SEL_ENGREG = 2'd3
  } regSel_e;

  // strobes from control to datapath
  typedef struct packed {
    logic pushOut;
    logic popOut;
    logic pushIn;
    logic popIn;
    logic flush;
  } strobe_t;

  typedef struct packed {
    logic err;
    logic rst;
    logic ready;
    logic irqSt;
    logic irqEn;
  } flags_t;

  function automatic logic [WORD_W-1:0] packStatus(
    input flags_t f,
    input logic [PTR_W-1:0] rdPtr,
    input logic [PTR_W-1:0] wrPtr,
    input logic [PTR_W-1:0] depth
  );
    logic [WORD_W-1:0] w;
    w = '0;
    w[BIT_IE]  = f.irqEn;
    w[BIT_IS]  = f.irqSt;
    w[BIT_RDY] = f.ready;
    w[BIT_RST] = f.rst;
    w[BIT_ERR] = f.err;
    w[RP_LSB +: PTR_W]  = rdPtr;
    w[WP_LSB +: PTR_W]  = wrPtr;
    w[DEP_LSB +: PTR_W] = depth;
    return w;
  endfunction

endpackage

// File: rtl/mbox_ring.sv
module mbox_ring #(
  parameter int DEPTH = 16,
  parameter int WIDTH = 32,
  parameter int PTR_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             push,
  input  logic             pop,
  input  logic             flush,
  input  logic [WIDTH-1:0] wrData,
  output logic [WIDTH-1:0] headData,
  output logic [PTR_W-1:0] wrPtr,
  output logic [PTR_W-1:0] rdPtr
);
  // DEPTH must be a power of two no larger than 2**(PTR_W-1)
  localparam int IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [WIDTH-1:0] slotMem [DEPTH];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else if (flush) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (push) wrPtr <= wrPtr + 1'b1;
      if (pop)  rdPtr <= rdPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push && !flush) slotMem[wrPtr[IDX_W-1:0]] <= wrData;
  end

  assign headData = slotMem[rdPtr[IDX_W-1:0]];

endmodule

// File: rtl/mbox_data.sv
module mbox_data
  import mbox_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strobe,
  input  logic [WORD_W-1:0] hostWrData,
  input  logic [WORD_W-1:0] engPushData,
  output logic [WORD_W-1:0] outHead,
  output logic [WORD_W-1:0] inHead,
  output logic [PTR_W-1:0]  outWr,
  output logic [PTR_W-1:0]  outRd,
  output logic [PTR_W-1:0]  inWr,
  output logic [PTR_W-1:0]  inRd
);
  localparam int N_RING = 2;  // index 0 outbound, 1 inbound

  logic [N_RING-1:0]  pushVec;
  logic [N_RING-1:0]  popVec;
  logic [WORD_W-1:0]  dataVec [N_RING];
  logic [WORD_W-1:0]  headVec [N_RING];
  logic [PTR_W-1:0]   wrVec   [N_RING];
  logic [PTR_W-1:0]   rdVec   [N_RING];

  assign pushVec    = {strobe.pushIn, strobe.pushOut};
  assign popVec     = {strobe.popIn,  strobe.popOut};
  assign dataVec[0] = hostWrData;
  assign dataVec[1] = engPushData;

  for (genvar g = 0; g < N_RING; g++) begin : gRing
    mbox_ring #(
      .DEPTH(DEPTH),
      .WIDTH(WORD_W),
      .PTR_W(PTR_W)
    ) uRing (
      .clk     (clk),
      .rstN    (rstN),
      .push    (pushVec[g]),
      .pop     (popVec[g]),
      .flush   (strobe.flush),
      .wrData  (dataVec[g]),
      .headData(headVec[g]),
      .wrPtr   (wrVec[g]),
      .rdPtr   (rdVec[g])
    );
  end

  assign outHead = headVec[0];
  assign inHead  = headVec[1];
  assign outWr   = wrVec[0];
  assign outRd   = rdVec[0];
  assign inWr    = wrVec[1];
  assign inRd    = rdVec[1];

endmodule

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              hostWrEn,
  input  logic              hostRdEn,
  input  logic [3:2]        hostAddr,
  input  logic [WORD_W-1:0] hostWrData,
  input  logic              engPush,
  input  logic              engPop,
  input  logic              engCsrWr,
  input  logic [5:0]        engCsrWrData,
  input  logic [WORD_W-1:0] outHead,
  input  logic [WORD_W-1:0] inHead,
  input  logic [PTR_W-1:0]  outWr,
  input  logic [PTR_W-1:0]  outRd,
  input  logic [PTR_W-1:0]  inWr,
  input  logic [PTR_W-1:0]  inRd,
  output strobe_t           strobe,
  output logic [WORD_W-1:0] hostRdData,
  output logic [WORD_W-1:0] engPopData,
  output logic [WORD_W-1:0] hostStatus,
  output logic [WORD_W-1:0] engStatus,
  output logic              hostIrq,
  output logic              engIrq,
  output logic              hostDoorbell,
  output logic              engDoorbell
);
  localparam logic [PTR_W-1:0] DEPTH_V = PTR_W'(DEPTH);

  regSel_e sel;
  logic hostCsrWr, hostTxWr, hostRxRd;
  logic flushNow;
  logic [PTR_W-1:0] outFill, inFill;
  logic outFull, outEmpty, inFull, inEmpty;
  logic hostDrop, engDrop;
  flags_t hostFlags, engFlags;

  // host access decode
  assign sel       = regSel_e'(hostAddr);
  assign hostCsrWr = hostWrEn && (sel == SEL_HOSTREG);
  assign hostTxWr  = hostWrEn && (sel == SEL_TXWIN);
  assign hostRxRd  = hostRdEn && (sel == SEL_RXWIN);

  // reset bit being written or held empties both buffers
  assign flushNow = hostFlags.rst | (hostCsrWr & hostWrData[BIT_RST]);

  // occupancy as 8-bit pointer differences
  assign outFill  = outWr - outRd;
  assign inFill   = inWr - inRd;
  assign outFull  = (outFill == DEPTH_V);
  assign outEmpty = (outFill == '0);
  assign inFull   = (inFill == DEPTH_V);
  assign inEmpty  = (inFill == '0);

  always_comb begin
    strobe         = '0;
    strobe.flush   = flushNow;
    strobe.pushOut = hostTxWr & ~flushNow & ~outFull;
    strobe.popIn   = hostRxRd & ~flushNow & ~inEmpty;
    strobe.pushIn  = engPush  & ~flushNow & ~inFull;
    strobe.popOut  = engPop   & ~flushNow & ~outEmpty;
  end

  assign hostDrop = ~flushNow & ((hostTxWr & outFull) | (hostRxRd & inEmpty));
  assign engDrop  = ~flushNow & ((engPush & inFull) | (engPop & outEmpty));

  // host-side flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      hostFlags <= '0;
    end else begin
      if (hostCsrWr) begin
        hostFlags.irqEn <= hostWrData[BIT_IE];
        hostFlags.rst   <= hostWrData[BIT_RST];
        hostFlags.ready <= hostWrData[BIT_RDY] & ~hostWrData[BIT_RST];
      end
      if (engCsrWr && engCsrWrData[BIT_IG]) begin
        hostFlags.irqSt <= 1'b1;
      end else if (hostCsrWr && hostWrData[BIT_IS]) begin
        hostFlags.irqSt <= 1'b0;
      end
      if (hostDrop) begin
        hostFlags.err <= 1'b1;
      end else if (hostCsrWr && hostWrData[BIT_ERR]) begin
        hostFlags.err <= 1'b0;
      end
    end
  end

  // engine-side flags
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      engFlags <= '0;
    end else begin
      if (engCsrWr) begin
        engFlags.irqEn <= engCsrWrData[BIT_IE];
        engFlags.rst   <= engCsrWrData[BIT_RST];
      end
      if (hostCsrWr && hostWrData[BIT_RST]) begin
        engFlags.ready <= 1'b0;
      end else if (engCsrWr) begin
        engFlags.ready <= engCsrWrData[BIT_RDY];
      end
      if (hostCsrWr && hostWrData[BIT_IG]) begin
        engFlags.irqSt <= 1'b1;
      end else if (engCsrWr && engCsrWrData[BIT_IS]) begin
        engFlags.irqSt <= 1'b0;
      end
      if (engDrop) begin
        engFlags.err <= 1'b1;
      end else if (engCsrWr && engCsrWrData[BIT_ERR]) begin
        engFlags.err <= 1'b0;
      end
    end
  end

  // doorbell pulses, one cycle after the generating write
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      engDoorbell  <= 1'b0;
      hostDoorbell <= 1'b0;
    end else begin
      engDoorbell  <= hostCsrWr & hostWrData[BIT_IG];
      hostDoorbell <= engCsrWr & engCsrWrData[BIT_IG];
    end
  end

  assign hostStatus = packStatus(hostFlags, outRd, outWr, DEPTH_V);
  assign engStatus  = packStatus(engFlags, inRd, inWr, DEPTH_V);

  always_comb begin
    unique case (sel)
      SEL_TXWIN:   hostRdData = '0;
      SEL_HOSTREG: hostRdData = hostStatus;
      SEL_RXWIN:   hostRdData = inEmpty ? '0 : inHead;
      SEL_ENGREG:  hostRdData = engStatus;
      default:     hostRdData = '0;
    endcase
  end

  assign engPopData = outEmpty ? '0 : outHead;
  assign hostIrq    = hostFlags.irqSt & hostFlags.irqEn;
  assign engIrq     = engFlags.irqSt & engFlags.irqEn;

endmodule

// File: rtl/mbox_top.sv
module mbox_top
  import mbox_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        hostWrEn,
  input  logic        hostRdEn,
  input  logic [3:2]  hostAddr,
  input  logic [31:0] hostWrData,
  output logic [31:0] hostRdData,
  input  logic        engPush,
  input  logic [31:0] engPushData,
  input  logic        engPop,
  output logic [31:0] engPopData,
  input  logic        engCsrWr,
  input  logic [5:0]  engCsrWrData,
  output logic [31:0] engStatus,
  output logic        hostIrq,
  output logic        engIrq,
  output logic        hostDoorbell,
  output logic        engDoorbell
);
  strobe_t strobe;
  logic [WORD_W-1:0] outHead, inHead, hostStatus;
  logic [PTR_W-1:0]  outWr, outRd, inWr, inRd;

  mbox_ctrl #(.DEPTH(DEPTH)) uCtrl (
    .clk         (clk),
    .rstN        (rstN),
    .hostWrEn    (hostWrEn),
    .hostRdEn    (hostRdEn),
    .hostAddr    (hostAddr),
    .hostWrData  (hostWrData),
    .engPush     (engPush),
    .engPop      (engPop),
    .engCsrWr    (engCsrWr),
    .engCsrWrData(engCsrWrData),
    .outHead     (outHead),
    .inHead      (inHead),
    .outWr       (outWr),
    .outRd       (outRd),
    .inWr        (inWr),
    .inRd        (inRd),
    .strobe      (strobe),
    .hostRdData  (hostRdData),
    .engPopData  (engPopData),
    .hostStatus  (hostStatus),
    .engStatus   (engStatus),
    .hostIrq     (hostIrq),
    .engIrq      (engIrq),
    .hostDoorbell(hostDoorbell),
    .engDoorbell (engDoorbell)
  );

  mbox_data #(.DEPTH(DEPTH)) uData (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .hostWrData (hostWrData),
    .engPushData(engPushData),
    .outHead    (outHead),
    .inHead     (inHead),
    .outWr      (outWr),
    .outRd      (outRd),
    .inWr       (inWr),
    .inRd       (inRd)
  );

endmodule

// File: rtl/mbox_chk.sv
module mbox_chk #(
  parameter int DEPTH = 16
) (
  input logic        clk,
  input logic        rstN,
  input logic        hostWrEn,
  input logic        hostRdEn,
  input logic [3:2]  hostAddr,
  input logic [31:0] hostWrData,
  input logic [31:0] hostRdData,
  input logic [31:0] hostStatus,
  input logic [31:0] engStatus,
  input logic        engDoorbell
);
  logic [7:0] outFill, inFill;
  assign outFill = hostStatus[23:16] - hostStatus[15:8];
  assign inFill  = engStatus[23:16] - engStatus[15:8];

  AST_FILL_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    (outFill <= 8'(DEPTH)) && (inFill <= 8'(DEPTH))) else $error("fill bound"); // R4

  AST_FULL_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (hostWrEn && hostAddr == 2'd0 && outFill == 8'(DEPTH) && !hostStatus[4])
      |=> $stable(hostStatus[23:16])) else $error("full write moved pointer"); // R5

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rstN)
    (hostStatus[5] && !(hostWrEn && hostAddr == 2'd1 && hostWrData[5]))
      |=> hostStatus[5]) else $error("error flag lost"); // R5

  AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (hostRdEn && hostAddr == 2'd2 && inFill == 8'd0) |-> (hostRdData == 32'd0))
    else $error("empty read data"); // R6

  AST_DOORBELL_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    engDoorbell |-> engStatus[1]) else $error("doorbell without status"); // R8

  AST_RESET_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    hostStatus[4] |-> (hostStatus[23:8] == 16'd0 && engStatus[23:8] == 16'd0))
    else $error("pointers during reset"); // R10

  AST_RESET_DROPS_READY: assert property (@(posedge clk) disable iff (!rstN)
    $rose(hostStatus[4]) |-> !engStatus[3]) else $error("engine ready kept"); // R10

endmodule

bind mbox_top mbox_chk #(.DEPTH(DEPTH)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .hostWrEn   (hostWrEn),
  .hostRdEn   (hostRdEn),
  .hostAddr   (hostAddr),
  .hostWrData (hostWrData),
  .hostRdData (hostRdData),
  .hostStatus (hostStatus),
  .engStatus  (engStatus),
  .engDoorbell(engDoorbell)
);

// File: tb/tb_mbox_top.sv
`timescale 1ns/1ps
module tb_mbox_top;
  localparam int DEPTH = 16;
  localparam logic [31:0] DEP = 32'(DEPTH) << 24;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        hostWrEn = 1'b0, hostRdEn = 1'b0;
  logic [3:2]  hostAddr = '0;
  logic [31:0] hostWrData = '0;
  logic [31:0] hostRdData;
  logic        engPush = 1'b0, engPop = 1'b0;
  logic [31:0] engPushData = '0;
  logic [31:0] engPopData;
  logic        engCsrWr = 1'b0;
  logic [5:0]  engCsrWrData = '0;
  logic [31:0] engStatus;
  logic        hostIrq, engIrq, hostDoorbell, engDoorbell;

  int checks = 0;
  int failures = 0;
  logic [31:0] txQ[$];
  logic [31:0] rxQ[$];
  logic [31:0] rd;

  always #2 clk = ~clk;

  mbox_top #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN),
    .hostWrEn(hostWrEn), .hostRdEn(hostRdEn), .hostAddr(hostAddr),
    .hostWrData(hostWrData), .hostRdData(hostRdData),
    .engPush(engPush), .engPushData(engPushData),
    .engPop(engPop), .engPopData(engPopData),
    .engCsrWr(engCsrWr), .engCsrWrData(engCsrWrData), .engStatus(engStatus),
    .hostIrq(hostIrq), .engIrq(engIrq),
    .hostDoorbell(hostDoorbell), .engDoorbell(engDoorbell)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hostWrite(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    hostWrEn = 1'b1; hostAddr = a; hostWrData = d;
    @(negedge clk);
    hostWrEn = 1'b0; hostWrData = '0;
  endtask

  task automatic hostRead(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    hostRdEn = 1'b1; hostAddr = a;
    #1 d = hostRdData;
    @(negedge clk);
    hostRdEn = 1'b0;
  endtask

  task automatic engCsrWrite(input logic [5:0] d);
    @(negedge clk);
    engCsrWr = 1'b1; engCsrWrData = d;
    @(negedge clk);
    engCsrWr = 1'b0; engCsrWrData = '0;
  endtask

  // scoreboard driver: host -> engine
  task automatic hostPush(input logic [31:0] d, input bit accept);
    hostWrite(2'd0, d);
    if (accept) txQ.push_back(d);
  endtask

  // scoreboard monitor: engine pops and compares with the queue head
  task automatic engPull(input string req);
    logic [31:0] exp;
    @(negedge clk);
    engPop = 1'b1;
    #1 exp = (txQ.size() > 0) ? txQ.pop_front() : 32'd0;
    check(engPopData === exp, req, engPopData, exp);
    @(negedge clk);
    engPop = 1'b0;
  endtask

  task automatic engFeed(input logic [31:0] d, input bit accept);
    @(negedge clk);
    engPush = 1'b1; engPushData = d;
    @(negedge clk);
    engPush = 1'b0;
    if (accept) rxQ.push_back(d);
  endtask

  task automatic hostPull(input string req);
    logic [31:0] exp, got;
    exp = (rxQ.size() > 0) ? rxQ.pop_front() : 32'd0;
    hostRead(2'd2, got);
    check(got === exp, req, got, exp);
  endtask

  initial begin
    #(4 * 150000);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1 / R13 reset state
    #1;
    check(engStatus === DEP, "R1 engine status", engStatus, DEP);
    check(hostIrq === 1'b0 && engIrq === 1'b0, "R1 irqs", {hostIrq, engIrq}, 0);
    hostRead(2'd1, rd);
    check(rd === DEP, "R13 host status depth", rd, DEP);

    // R2 host to engine in order
    hostPush(32'hA1A1_0001, 1'b1);
    hostPush(32'hB2B2_0002, 1'b1);
    hostPush(32'hC3C3_0003, 1'b1);
    hostRead(2'd1, rd);
    check(rd === (DEP | 32'h0003_0000), "R2 write pointer", rd, DEP | 32'h0003_0000);
    repeat (3) engPull("R2 order");
    hostRead(2'd1, rd);
    check(rd === (DEP | 32'h0003_0300), "R2 read pointer", rd, DEP | 32'h0003_0300);

    // R3 engine to host
    engFeed(32'h1111_AAAA, 1'b1);
    engFeed(32'h2222_BBBB, 1'b1);
    check(engStatus === (DEP | 32'h0002_0000), "R3 write pointer", engStatus, DEP | 32'h0002_0000);
    hostPull("R3 order");
    hostPull("R3 order");
    check(engStatus === (DEP | 32'h0002_0200), "R3 read pointer", engStatus, DEP | 32'h0002_0200);

    // R12 inert window accesses
    hostRead(2'd0, rd);
    check(rd === 32'd0, "R12 read of write window", rd, 0);
    hostWrite(2'd3, 32'hFFFF_FFFF);
    hostWrite(2'd2, 32'h5555_5555);
    check(engStatus === (DEP | 32'h0002_0200), "R12 ignored writes", engStatus, DEP | 32'h0002_0200);

    // R6 empty host read
    hostRead(2'd2, rd);
    check(rd === 32'd0, "R6 empty data", rd, 0);
    check(engStatus === (DEP | 32'h0002_0200), "R6 pointers held", engStatus, DEP | 32'h0002_0200);
    hostRead(2'd1, rd);
    check(rd === (DEP | 32'h0003_0320), "R6 error flag", rd, DEP | 32'h0003_0320);
    hostWrite(2'd1, 32'h20);
    hostRead(2'd1, rd);
    check(rd === (DEP | 32'h0003_0300), "R5 error cleared", rd, DEP | 32'h0003_0300);

    // R5 outbound full
    for (int i = 0; i < DEPTH; i++) hostPush(32'hF000_0000 + i, 1'b1);
    hostRead(2'd1, rd);
    check(rd === (DEP | 32'h0013_0300), "R5 full level", rd, DEP | 32'h0013_0300);
    hostPush(32'hDEAD_BEEF, 1'b0);
    hostRead(2'd1, rd);
    check(rd === (DEP | 32'h0013_0320), "R5 drop sets error", rd, DEP | 32'h0013_0320);
    hostRead(2'd1, rd);
    check(rd[5] === 1'b1, "R5 error sticky", rd, 32'h20);
    hostWrite(2'd1, 32'h20);
    for (int i = 0; i < DEPTH; i++) engPull("R5 drain order");

    // R7 engine side drops
    engPull("R7 empty pop data");
    check(engStatus === (DEP | 32'h0002_0220), "R7 pop error", engStatus, DEP | 32'h0002_0220);
    engCsrWrite(6'h20);
    for (int i = 0; i < DEPTH; i++) engFeed(32'hE000_0000 + i, 1'b1);
    engFeed(32'hBAD0_BAD0, 1'b0);
    check(engStatus === (DEP | 32'h0012_0220), "R7 push error", engStatus, DEP | 32'h0012_0220);
    engCsrWrite(6'h20);
    for (int i = 0; i < DEPTH; i++) hostPull("R7 drain order");
    check(engStatus === (DEP | 32'h0012_1200), "R7 error cleared", engStatus, DEP | 32'h0012_1200);

    // R4 pointer wrap over 300 transfers
    for (int i = 0; i < 300; i++) begin
      hostPush(32'h0700_0000 + i, 1'b1);
      engPull("R4 wrap order");
    end
    hostRead(2'd1, rd);
    check(rd === (DEP | 32'h003F_3F00), "R4 wrapped pointers", rd, DEP | 32'h003F_3F00);

    // R8 doorbell toward engine
    hostWrite(2'd1, 32'h04);
    check(engDoorbell === 1'b1, "R8 doorbell pulse", engDoorbell, 1);
    check(engStatus[1] === 1'b1, "R8 engine status set", engStatus, 32'h2);
    hostRead(2'd1, rd);
    check(engDoorbell === 1'b0, "R8 single cycle", engDoorbell, 0);
    check(rd[2] === 1'b0, "R8 generate reads zero", rd, 0);
    check(engIrq === 1'b0, "R8 masked", engIrq, 0);
    engCsrWrite(6'h01);
    check(engIrq === 1'b1, "R8 engine irq", engIrq, 1);
    engCsrWrite(6'h03);
    check(engIrq === 1'b0 && engStatus[1] === 1'b0, "R8 clear", engStatus, 32'h1);

    // R9 doorbell toward host
    hostWrite(2'd1, 32'h01);
    engCsrWrite(6'h05);
    check(hostDoorbell === 1'b1, "R9 doorbell pulse", hostDoorbell, 1);
    check(hostIrq === 1'b1, "R9 host irq", hostIrq, 1);
    hostWrite(2'd1, 32'h03);
    check(hostIrq === 1'b0 && hostDoorbell === 1'b0, "R9 clear", {hostIrq, hostDoorbell}, 0);

    // R10 reset handshake, flush
    hostPush(32'h1234_0001, 1'b1);
    hostPush(32'h1234_0002, 1'b1);
    engFeed(32'h4321_0001, 1'b1);
    engCsrWrite(6'h08);
    check(engStatus[3] === 1'b1, "R10 engine ready set", engStatus, 32'h8);
    hostWrite(2'd1, 32'h1C);
    txQ.delete();
    rxQ.delete();
    check(engDoorbell === 1'b1, "R10 reset doorbell", engDoorbell, 1);
    check(engStatus[23:8] === 16'd0 && engStatus[3] === 1'b0, "R10 engine flushed", engStatus, DEP);
    hostRead(2'd1, rd);
    check((rd & 32'h00FF_FF3F) === 32'h10, "R10 host flushed", rd, 32'h10);
    hostPush(32'h9999_9999, 1'b0);
    engFeed(32'h8888_8888, 1'b0);
    engPull("R10 pop ignored");
    hostRead(2'd1, rd);
    check((rd & 32'h00FF_FF3F) === 32'h10, "R10 host ignores", rd, 32'h10);
    check(engStatus[23:8] === 16'd0 && engStatus[5] === 1'b0, "R10 engine ignores", engStatus, DEP);

    // R11 release
    engCsrWrite(6'h08);
    hostWrite(2'd1, 32'h0C);
    hostRead(2'd1, rd);
    check((rd & 32'h1F) === 32'h08, "R11 host ready", rd, 32'h08);
    check(engStatus[3] === 1'b1, "R11 engine ready", engStatus, 32'h8);
    hostPush(32'h600D_F00D, 1'b1);
    engPull("R11 traffic resumes");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule